// File: doc/BRIEF.md
# SPI Readout Tap with Appended Status Byte

This block sits on the serial link between a microcontroller acting as SPI master and an external 24-bit ADC. When the ADC raises its data-ready line, the block takes a snapshot of the measurement context. The snapshot holds the context bits, the state of the range-selection logic and a flag that says whether the range moved since the previous capture. The block then tells the range logic to clear that flag, and passes the ready indication on to the microcontroller.

The microcontroller answers with one 32-clock read. For the first 24 clocks the block is transparent: the ADC sees the master's clock and select, and its MISO goes straight back to the master. When the ADC's word is done, the block cuts the ADC off from the link. It then shifts the 8-bit snapshot onto MISO, most significant bit first, so the master receives one combined word: the ADC sample in the top 24 bits and the status byte in the bottom 8.

The serial clock, chip select and data-ready are sampled by a fast system clock through synchronizers. The serial clock therefore has to stay slow relative to the system clock. The snapshot is double-buffered: a new data-ready during a read leaves the byte being shifted untouched and is delivered on the next read.

Top module: `spi_status_tap`

## Requirements
- R1: After reset, `mcu_drdy_o` and `chg_clr_o` are 0 and the snapshot is all zeros, so a read before any data-ready returns 0 in its low 8 bits.
- R2: A rising edge of `adc_drdy_i` stores the status byte {`ctx_i`[4:0] in bits 7:3, `range_chg_i` in bit 2, `range_i`[1:0] in bits 1:0} and produces exactly one system-clock cycle of `chg_clr_o` high.
- R3: `mcu_drdy_o` rises exactly one system clock after the `chg_clr_o` pulse and falls again after `adc_drdy_i` falls.
- R4: For serial bits 1 to 24 of a frame, `mcu_miso_o` carries `adc_miso_i`, and the ADC receives the master's clock and select; the assembled word's bits 31:8 equal the ADC's 24-bit word.
- R5: For serial bits 25 to 32, `mcu_miso_o` carries the stored status byte MSB first, one bit per serial clock, so the word's bits 7:0 equal the byte laid out as in R2.
- R6: After the 24th serial rising edge the ADC is isolated: in the default mode `adc_cs_n_o` goes high; the ADC sees exactly 24 rising clock edges while selected.
- R7: A data-ready edge during a read does not change the byte shifted in that read; the next read returns the newly captured byte.
- R8: Deasserting chip select clears the bit count, so a read cut short and followed by a full read starts again with the ADC's most significant bit.
- R9: Without a new data-ready, repeated reads return the same status byte.
- R10: A capture with `range_chg_i` low yields bit 2 of the word as 0 while the context and range bits still follow the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| adc_drdy_i | input | 1 | Data-ready from the ADC, active high |
| ctx_i | input | 5 | Context bits to capture |
| range_i | input | 2 | Current range state from the range logic |
| range_chg_i | input | 1 | Range-moved flag from the range logic |
| chg_clr_o | output | 1 | One-cycle pulse telling the range logic to clear its flag |
| mcu_drdy_o | output | 1 | Data-ready forwarded to the microcontroller |
| mcu_sclk_i | input | 1 | Serial clock from the master (mode 0) |
| mcu_cs_n_i | input | 1 | Active-low chip select from the master |
| mcu_miso_o | output | 1 | Serial data to the master |
| adc_sclk_o | output | 1 | Serial clock to the ADC |
| adc_cs_n_o | output | 1 | Active-low chip select to the ADC |
| adc_miso_i | input | 1 | Serial data from the ADC |

## Verification
The bench targets the handover at bit 24. If the phase switch came one serial clock early or late, the status byte would shift by one place against the ADC word. If the ADC were not isolated, it would see more than 24 edges. A data-ready landing mid-read is also driven. If the double buffer were missing, that read would return a mix of old and new status bits. An aborted read checks that the count clears. If it did not, the next frame would open in the status phase. The flag-clear pulse and the forwarded ready are timed to the cycle. A pulse that was too long, or a ready that came too early, would let the master read a snapshot that was not yet stored.

// File: rtl/spi_tap_pkg.sv
package spi_tap_pkg;
   // How the ADC is kept from shifting once its word is out
   typedef enum logic {
      ISO_CS_RELEASE = 1'b0,   // drive the ADC select high
      ISO_CLK_GATE   = 1'b1    // hold the ADC clock low, select follows master
   } iso_mode_e;
endpackage

// File: rtl/spi_tap_sync.sv
module spi_tap_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d_i,
   output logic [W-1:0]  q_o
);
   initial begin
      assert (STAGES >= 2) else $error("spi_tap_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= RST_VAL;
            else if (s == 0) stage_q[s] <= d_i;
            else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_tap_snap.sv
module spi_tap_snap #(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              drdy_s_i,
   input  logic [STAT_W-1:0] stat_i,
   output logic [STAT_W-1:0] snap_o,
   output logic              clr_o,
   output logic              drdy_o
);
   logic              drdy_d;
   logic              cap;
   logic [STAT_W-1:0] snap_q;
   logic              clr_q;
   logic              fwd_q;

   assign cap = drdy_s_i & ~drdy_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drdy_d <= 1'b0;
         snap_q <= '0;
         clr_q  <= 1'b0;
         fwd_q  <= 1'b0;
      end else begin
         drdy_d <= drdy_s_i;
         clr_q  <= cap;
         fwd_q  <= drdy_d;     // lags the capture by one clock
         if (cap) snap_q <= stat_i;
      end
   end

   assign snap_o = snap_q;
   assign clr_o  = clr_q;
   assign drdy_o = fwd_q;

   // R2: the flag-clear request lasts a single clock
   p_clr_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      clr_q |=> !clr_q);

   // R3: forwarded ready only rises right after a capture
   p_drdy_after_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fwd_q) |-> $past(clr_q));
endmodule

// File: rtl/spi_tap_shift.sv
module spi_tap_shift #(
   parameter int ADC_BITS = 24,
   parameter int STAT_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s_i,
   input  logic              cs_n_s_i,
   input  logic [STAT_W-1:0] snap_i,
   output logic              adc_phase_o,
   output logic              stat_bit_o
);
   localparam int FRAME = ADC_BITS + STAT_W;
   localparam int CNT_W = $clog2(FRAME + 1);
   localparam logic [CNT_W-1:0] ADC_END = CNT_W'(ADC_BITS);
   localparam logic [CNT_W-1:0] FR_END  = CNT_W'(FRAME);

   initial begin
      assert (STAT_W >= 2) else $error("spi_tap_shift: STAT_W must be at least 2");
      assert (ADC_BITS >= 1) else $error("spi_tap_shift: ADC_BITS must be positive");
   end

   logic              sclk_d, cs_d;
   logic [CNT_W-1:0]  cnt_q;
   logic [STAT_W-1:0] sh_q;
   logic              rise, fall, cs_fall, shift_en;

   assign rise     = sclk_s_i & ~sclk_d;
   assign fall     = ~sclk_s_i & sclk_d;
   assign cs_fall  = ~cs_n_s_i & cs_d;
   // the first status bit is already on MISO; advance after it was sampled
   assign shift_en = ~cs_n_s_i & fall & (cnt_q > ADC_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d <= 1'b0;
         cs_d   <= 1'b1;
         cnt_q  <= '0;
         sh_q   <= '0;
      end else begin
         sclk_d <= sclk_s_i;
         cs_d   <= cs_n_s_i;
         if (cs_n_s_i)                  cnt_q <= '0;
         else if (rise && cnt_q != FR_END) cnt_q <= cnt_q + 1'b1;
         if (cs_fall)       sh_q <= snap_i;      // second buffer loads at frame start
         else if (shift_en) sh_q <= {sh_q[STAT_W-2:0], 1'b0};
      end
   end

   assign adc_phase_o = (cnt_q < ADC_END);
   assign stat_bit_o  = sh_q[STAT_W-1];

   // R8: count never runs past one frame
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FR_END);

   // R8: an idle select leaves the count at zero
   p_cnt_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s_i |=> cnt_q == '0);

   // R7: inside a frame the shifted byte only moves on its own shift edges
   p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n_s_i && !cs_fall && !shift_en) |=> $stable(sh_q));
endmodule

// File: rtl/spi_status_tap.sv
module spi_status_tap
   import spi_tap_pkg::*;
#(
   parameter int        ADC_BITS    = 24,
   parameter int        CTX_W       = 5,
   parameter int        RANGE_W     = 2,
   parameter int        SYNC_STAGES = 2,
   parameter iso_mode_e ISO_MODE    = ISO_CS_RELEASE
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               adc_drdy_i,
   input  logic [CTX_W-1:0]   ctx_i,
   input  logic [RANGE_W-1:0] range_i,
   input  logic               range_chg_i,
   output logic               chg_clr_o,
   output logic               mcu_drdy_o,
   input  logic               mcu_sclk_i,
   input  logic               mcu_cs_n_i,
   output logic               mcu_miso_o,
   output logic               adc_sclk_o,
   output logic               adc_cs_n_o,
   input  logic               adc_miso_i
);
   localparam int STAT_W = CTX_W + 1 + RANGE_W;

   initial begin
      assert (CTX_W >= 1 && RANGE_W >= 1) else $error("spi_status_tap: field widths must be positive");
   end

   logic [2:0]        sync_q;
   logic [STAT_W-1:0] stat;
   logic [STAT_W-1:0] snap;
   logic              adc_phase, stat_bit;

   // {data-ready, select, clock}; idle values are 0, 1, 0
   spi_tap_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({adc_drdy_i, mcu_cs_n_i, mcu_sclk_i}),
      .q_o   (sync_q)
   );

   assign stat = {ctx_i, range_chg_i, range_i};

   spi_tap_snap #(.STAT_W(STAT_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .drdy_s_i (sync_q[2]),
      .stat_i   (stat),
      .snap_o   (snap),
      .clr_o    (chg_clr_o),
      .drdy_o   (mcu_drdy_o)
   );

   spi_tap_shift #(.ADC_BITS(ADC_BITS), .STAT_W(STAT_W)) u_shift (
      .clk         (clk),
      .rst_n       (rst_n),
      .sclk_s_i    (sync_q[0]),
      .cs_n_s_i    (sync_q[1]),
      .snap_i      (snap),
      .adc_phase_o (adc_phase),
      .stat_bit_o  (stat_bit)
   );

   assign mcu_miso_o = adc_phase ? adc_miso_i : stat_bit;

   generate
      if (ISO_MODE == ISO_CS_RELEASE) begin : g_cs_release
         assign adc_cs_n_o = mcu_cs_n_i | ~adc_phase;
         assign adc_sclk_o = mcu_sclk_i;
      end else begin : g_clk_gate
         assign adc_cs_n_o = mcu_cs_n_i;
         assign adc_sclk_o = mcu_sclk_i & adc_phase;
      end
   endgenerate
endmodule

// File: tb/spi_status_tap_test.sv
module spi_status_tap_test;
   localparam int HALF = 8;   // system clocks per serial half period

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic adc_drdy = 1'b0;
   logic [4:0] ctx = '0;
   logic [1:0] rng = '0;
   logic range_chg = 1'b0;
   logic flag_set = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic chg_clr_o, mcu_drdy_o, mcu_miso_o, adc_sclk_o, adc_cs_n_o, adc_miso_i;

   logic [23:0] adc_word = '0;
   logic [23:0] adc_sr = '0;
   int          adc_rises = 0;
   int          n_chk = 0;
   int          n_err = 0;
   bit          done = 1'b0;

   logic [4:0]  inj_ctx = '0;
   logic [1:0]  inj_rng = '0;

   always #5 clk = ~clk;

   spi_status_tap uut (
      .clk(clk), .rst_n(rst_n), .adc_drdy_i(adc_drdy), .ctx_i(ctx), .range_i(rng),
      .range_chg_i(range_chg), .chg_clr_o(chg_clr_o), .mcu_drdy_o(mcu_drdy_o),
      .mcu_sclk_i(sclk), .mcu_cs_n_i(cs_n), .mcu_miso_o(mcu_miso_o),
      .adc_sclk_o(adc_sclk_o), .adc_cs_n_o(adc_cs_n_o), .adc_miso_i(adc_miso_i)
   );

   // range logic flag model: set on request, cleared by the block's pulse
   always @(posedge clk) begin
      if (flag_set) range_chg <= 1'b1;
      else if (chg_clr_o) range_chg <= 1'b0;
   end

   // ADC model, mode 0: output MSB, shift on falling clock while selected
   always @(negedge adc_cs_n_o) adc_sr = adc_word;
   always @(negedge adc_sclk_o) if (!adc_cs_n_o) adc_sr = {adc_sr[22:0], 1'b0};
   always @(posedge adc_sclk_o) if (!adc_cs_n_o) adc_rises = adc_rises + 1;
   assign adc_miso_i = adc_cs_n_o ? 1'b0 : adc_sr[23];

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic raise_flag();
      @(negedge clk); flag_set = 1'b1;
      @(negedge clk); flag_set = 1'b0;
      ticks(1);
   endtask

   // read nbits; at bit inj (if >=0) inject a new data-ready with inj_ctx/inj_rng
   task automatic spi_read(input int nbits, input int inj, output logic [31:0] w);
      w = '0;
      adc_rises = 0;
      @(negedge clk); cs_n = 1'b0;
      ticks(HALF);
      for (int i = 0; i < nbits; i++) begin
         w = {w[30:0], mcu_miso_o};
         sclk = 1'b1;
         if (i == inj) begin
            ctx = inj_ctx; rng = inj_rng; adc_drdy = 1'b1;
         end
         ticks(HALF);
         sclk = 1'b0;
         ticks(HALF);
      end
      cs_n = 1'b1;
      ticks(2*HALF);
   endtask

   // capture with cycle-level checks of the clear pulse and forwarded ready
   task automatic capture(input logic [4:0] c, input logic [1:0] r, input string tag);
      int waitc;
      @(negedge clk); ctx = c; rng = r; adc_drdy = 1'b1;
      waitc = 0;
      while (!chg_clr_o && waitc < 12) begin @(negedge clk); waitc++; end
      chk({31'b0, chg_clr_o}, 32'd1, {tag, " R2 clear pulse seen"});
      chk({31'b0, mcu_drdy_o}, 32'd0, {tag, " R3 ready not before capture"});
      @(negedge clk);
      chk({31'b0, chg_clr_o}, 32'd0, {tag, " R2 clear pulse one cycle"});
      chk({31'b0, mcu_drdy_o}, 32'd1, {tag, " R3 ready one cycle after clear"});
      chk({31'b0, range_chg}, 32'd0, {tag, " R2 flag cleared"});
   endtask

   task automatic drop_drdy();
      @(negedge clk); adc_drdy = 1'b0;
      ticks(6);
      chk({31'b0, mcu_drdy_o}, 32'd0, "R3 ready follows data-ready low");
   endtask

   task automatic t_reset();
      logic [31:0] w;
      chk({30'b0, chg_clr_o, mcu_drdy_o}, 32'd0, "R1 outputs idle after reset");
      adc_word = 24'hA5C33C;
      spi_read(32, -1, w);
      chk(w, {24'hA5C33C, 8'h00}, "R1 R4 empty snapshot read");
   endtask

   task automatic t_capture();
      logic [31:0] w;
      raise_flag();
      capture(5'h15, 2'd2, "cap");
      adc_word = 24'h123456;
      spi_read(32, -1, w);
      chk(w, {24'h123456, 5'h15, 1'b1, 2'd2}, "R4 R5 combined word");
      chk(adc_rises, 32'd24, "R6 ADC sees 24 edges");
      drop_drdy();
   endtask

   task automatic t_repeat();
      logic [31:0] w;
      adc_word = 24'hFEDCBA;
      spi_read(32, -1, w);
      chk(w, {24'hFEDCBA, 5'h15, 1'b1, 2'd2}, "R9 status held on re-read");
   endtask

   task automatic t_noflag();
      logic [31:0] w;
      capture(5'h0A, 2'd1, "noflag");
      adc_word = 24'h800001;
      spi_read(32, -1, w);
      chk(w, {24'h800001, 5'h0A, 1'b0, 2'd1}, "R10 flag bit low");
      drop_drdy();
      raise_flag();
      capture(5'h1F, 2'd3, "ones");
      adc_word = 24'h000000;
      spi_read(32, -1, w);
      chk(w, {24'h000000, 5'h1F, 1'b1, 2'd3}, "R5 all-ones status after zero ADC word");
      drop_drdy();
   endtask

   task automatic t_double();
      logic [31:0] w;
      capture(5'h03, 2'd0, "dbl");
      drop_drdy();
      inj_ctx = 5'h1C; inj_rng = 2'd3;
      adc_word = 24'h0F0F0F;
      spi_read(32, 27, w);
      chk(w, {24'h0F0F0F, 5'h03, 1'b0, 2'd0}, "R7 mid-status injection ignored");
      drop_drdy();
      adc_word = 24'h333333;
      spi_read(32, -1, w);
      chk(w, {24'h333333, 5'h1C, 1'b0, 2'd3}, "R7 new snapshot on next read");
      inj_ctx = 5'h11; inj_rng = 2'd1;
      adc_word = 24'h5A5A5A;
      spi_read(32, 9, w);
      chk(w, {24'h5A5A5A, 5'h1C, 1'b0, 2'd3}, "R7 mid-ADC injection ignored");
      drop_drdy();
   endtask

   task automatic t_abort();
      logic [31:0] w;
      adc_word = 24'hC0FFEE;
      spi_read(12, -1, w);
      chk(w, {20'b0, 12'hC0F}, "R8 partial read passes ADC bits");
      adc_word = 24'h13579B;
      spi_read(32, -1, w);
      chk(w, {24'h13579B, 5'h11, 1'b0, 2'd1}, "R8 full read after abort");
      chk(adc_rises, 32'd24, "R6 edge count after abort");
   endtask

   initial begin
      ticks(4);
      rst_n = 1'b1;
      ticks(4);
      t_reset();
      t_capture();
      t_repeat();
      t_noflag();
      t_double();
      t_abort();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++; n_err++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule